// File: doc/BRIEF.md
# Programmable Local Interrupt Timer

This block is a down-counting interval timer that runs on the bus clock and raises one local interrupt. Software programs three things through a small write port: a start count, a divide code, and a timer vector-table entry. The entry holds the interrupt vector, a mask bit and a periodic-mode bit. The time to expiry is the start count multiplied by a power-of-two ratio taken from the divide code. In one-shot mode the timer stops after the first expiry. In periodic mode it reloads at each expiry, and the reload period is never shorter than a minimum that the integrator sets as a parameter.

Expiries are not lost when the interrupt cannot be taken at once. Each expiry adds one to a saturating pending counter. While the counter is non-zero and the entry is unmasked, the block requests an interrupt and presents the entry's vector. Each acknowledge of a live request takes one off the counter. A software-enable level input gates the whole unit. While that input is low, the entry is forced to the masked state and the pending counter is held at zero. A current-count output reports how much of the present period remains, expressed in divided ticks.

Top module: `lit_timer`

## Requirements
- R1: After synchronous reset, timer_entry reads 0x00010000 (masked, one-shot, vector 0), cur_count reads 0, irq_req is low, and the divide code and start count are zero.
- R2: A write with wr_sel=1 stores the divide code from wr_data[3:0]. The ratio is 1 << ((({code[3],code[1:0]} + 1) mod 8)). Code 0 gives 2, code 0xB gives 1, code 0x3 gives 16 and code 0xA gives 128.
- R3: A write with wr_sel=0 loads the start count from wr_data and restarts the timer. The period becomes start count times ratio, in clock cycles. The same write clears the pending counter. The first expiry is registered P clock edges after the load edge.
- R4: A start count of zero leaves the timer stopped. cur_count then reads 0 and no expiry occurs.
- R5: cur_count reads floor(remaining cycles / current ratio). It reads 0 when the remaining cycles equal the period (the cycle after a load or a reload) and 0 when the timer is stopped.
- R6: In one-shot mode (entry bit 17 clear) the timer expires once and then stays stopped.
- R7: In periodic mode (entry bit 17 set at load time) the timer reloads at every expiry. A non-zero period smaller than MIN_PERIOD cycles is raised to MIN_PERIOD.
- R8: Each expiry adds one to the pending counter. The counter saturates at 2^PEND_W - 1.
- R9: irq_req is high exactly when the pending count is non-zero and entry bit 16 (mask) is clear, and irq_vector shows entry bits 7:0. An irq_ack in a cycle with irq_req high removes one pending expiry. irq_ack has no effect while irq_req is low.
- R10: An expiry and an accepted acknowledge on the same clock edge leave the pending count unchanged.
- R11: A write with wr_sel=2 keeps only entry bits 17, 16, 12 and 7:0. All other bits of timer_entry read 0. wr_sel=3 writes nothing.
- R12: While sw_enable is low, entry bit 16 is forced to 1, including on entry writes, and the pending counter is held at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sw_enable | input | 1 | Software enable level; low masks the entry and drops pending expiries |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Target: 0 start count, 1 divide code, 2 timer entry, 3 none |
| wr_data | input | 32 | Write data |
| irq_ack | input | 1 | Delivery acknowledge for the current request |
| irq_req | output | 1 | Timer interrupt request |
| irq_vector | output | 8 | Vector of the requested interrupt |
| timer_entry | output | 32 | Read view of the timer vector-table entry |
| cur_count | output | CNT_W | Remaining time of the current period in divided ticks |

## Verification
The two functions that can collide are an expiry of the count-down and an acknowledge that retires a pending expiry, both landing on the same edge. The bench builds this case on purpose. It lets a masked periodic timer collect two expiries, unmasks the entry, and then raises irq_ack for exactly the edge on which the third expiry falls. It judges the result by counting how many further acknowledges are needed before irq_req falls, which must be two. A bench model also runs alongside random traffic, where ack pulses and periodic expiries overlap by chance, and it compares the request and the count in every cycle.

// File: rtl/lit_pkg.sv
package lit_pkg;

    localparam int DATA_W    = 32;
    localparam int MAX_SHIFT = 7;

    typedef enum logic [1:0] {
        SEL_INIT   = 2'd0,
        SEL_DIVIDE = 2'd1,
        SEL_ENTRY  = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    // Timer vector-table entry as held in flops.
    typedef struct packed {
        logic       periodic;   // word bit 17
        logic       masked;     // word bit 16
        logic       status;     // word bit 12
        logic [7:0] vector;     // word bits 7:0
    } entry_t;

    localparam entry_t ENTRY_RESET = '{periodic: 1'b0, masked: 1'b1,
                                       status: 1'b0, vector: 8'h00};

    function automatic entry_t unpack_entry(input logic [DATA_W-1:0] w);
        entry_t e;
        e.periodic = w[17];
        e.masked   = w[16];
        e.status   = w[12];
        e.vector   = w[7:0];
        return e;
    endfunction

    function automatic logic [DATA_W-1:0] pack_entry(input entry_t e);
        return {14'd0, e.periodic, e.masked, 3'd0, e.status, 4'd0, e.vector};
    endfunction

    // Ratio exponent from the scattered 3-bit code; wraps modulo 8.
    function automatic logic [2:0] divide_shift(input logic [3:0] code);
        return {code[3], code[1:0]} + 3'd1;
    endfunction

endpackage

// File: rtl/lit_cfg_regs.sv
module lit_cfg_regs
    import lit_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sw_enable,
    input  logic       wr_entry,
    input  entry_t     wr_entry_val,
    input  logic       wr_div,
    input  logic [3:0] wr_div_code,
    output entry_t     entry_q,
    output logic [2:0] shift
);

    logic [3:0] div_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            entry_q <= ENTRY_RESET;
        end else if (wr_entry) begin
            entry_q        <= wr_entry_val;
            entry_q.masked <= wr_entry_val.masked | ~sw_enable;
        end else if (!sw_enable) begin
            entry_q.masked <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
        end else if (wr_div) begin
            div_q <= wr_div_code;
        end
    end

    assign shift = divide_shift(div_q);

endmodule

// File: rtl/lit_countdown.sv
module lit_countdown
    import lit_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int MIN_PERIOD = 500000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             periodic,
    input  logic [2:0]       shift,
    output logic             expire,
    output logic [CNT_W-1:0] cur_count
);

    localparam int TW = CNT_W + MAX_SHIFT;
    localparam logic [TW-1:0] MIN_T = TW'(MIN_PERIOD);
    localparam logic [TW-1:0] ONE_T = TW'(1);

    logic [TW-1:0] per_q;
    logic [TW-1:0] rem_q;
    logic [TW-1:0] scaled;
    logic [TW-1:0] per_new;

    always_comb begin
        scaled  = TW'(load_val) << shift;
        per_new = scaled;
        if (load_val != '0 && periodic && scaled < MIN_T) begin
            per_new = MIN_T;
        end
    end

    assign expire = !load && (rem_q == ONE_T);

    always_ff @(posedge clk) begin
        if (rst) begin
            per_q <= '0;
            rem_q <= '0;
        end else if (load) begin
            per_q <= per_new;
            rem_q <= per_new;
        end else if (rem_q != '0) begin
            if (rem_q == ONE_T) begin
                rem_q <= periodic ? per_q : '0;
            end else begin
                rem_q <= rem_q - ONE_T;
            end
        end
    end

    // Remaining modulo period: only the full-period value wraps to zero.
    always_comb begin
        if (rem_q == '0 || rem_q == per_q) begin
            cur_count = '0;
        end else begin
            cur_count = CNT_W'(rem_q >> shift);
        end
    end

endmodule

// File: rtl/lit_pending.sv
module lit_pending #(
    parameter int PEND_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              expire,
    input  logic              clear,
    input  logic              ack,
    input  logic              masked,
    output logic              irq_req,
    output logic [PEND_W-1:0] pend_q
);

    localparam logic [PEND_W:0] SAT = {1'b0, {PEND_W{1'b1}}};

    logic [PEND_W:0] sum;
    logic            take;

    assign irq_req = (pend_q != '0) && !masked;
    assign take    = ack && irq_req;
    assign sum     = {1'b0, pend_q} + {{PEND_W{1'b0}}, expire}
                                    - {{PEND_W{1'b0}}, take};

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            pend_q <= '0;
        end else if (sum > SAT) begin
            pend_q <= SAT[PEND_W-1:0];
        end else begin
            pend_q <= sum[PEND_W-1:0];
        end
    end

endmodule

// File: rtl/lit_timer.sv
module lit_timer
    import lit_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int PEND_W     = 8,
    parameter int MIN_PERIOD = 500000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sw_enable,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [31:0]      wr_data,
    input  logic             irq_ack,
    output logic             irq_req,
    output logic [7:0]       irq_vector,
    output logic [31:0]      timer_entry,
    output logic [CNT_W-1:0] cur_count
);

    entry_t            entry_q;
    logic [2:0]        shift;
    logic              load_w;
    logic              expire_w;
    logic [PEND_W-1:0] pend_q;

    assign load_w = wr_en && (wr_sel == SEL_INIT);

    lit_cfg_regs u_cfg (
        .clk          (clk),
        .rst          (rst),
        .sw_enable    (sw_enable),
        .wr_entry     (wr_en && (wr_sel == SEL_ENTRY)),
        .wr_entry_val (unpack_entry(wr_data)),
        .wr_div       (wr_en && (wr_sel == SEL_DIVIDE)),
        .wr_div_code  (wr_data[3:0]),
        .entry_q      (entry_q),
        .shift        (shift)
    );

    lit_countdown #(
        .CNT_W      (CNT_W),
        .MIN_PERIOD (MIN_PERIOD)
    ) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .load      (load_w),
        .load_val  (wr_data[CNT_W-1:0]),
        .periodic  (entry_q.periodic),
        .shift     (shift),
        .expire    (expire_w),
        .cur_count (cur_count)
    );

    lit_pending #(
        .PEND_W (PEND_W)
    ) u_pend (
        .clk     (clk),
        .rst     (rst),
        .expire  (expire_w),
        .clear   (load_w || !sw_enable),
        .ack     (irq_ack),
        .masked  (entry_q.masked),
        .irq_req (irq_req),
        .pend_q  (pend_q)
    );

    assign irq_vector  = entry_q.vector;
    assign timer_entry = pack_entry(entry_q);

endmodule

// File: rtl/lit_timer_chk.sv
module lit_timer_chk #(
    parameter int CNT_W  = 32,
    parameter int PEND_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              sw_enable,
    input logic              wr_en,
    input logic [1:0]        wr_sel,
    input logic [CNT_W-1:0]  wr_count,
    input logic              irq_ack,
    input logic              irq_req,
    input logic              entry_masked,
    input logic [CNT_W-1:0]  cur_count,
    input logic              expire,
    input logic [PEND_W-1:0] pend_cnt
);

    localparam logic [PEND_W-1:0] P_ONE = PEND_W'(1);
    localparam logic [PEND_W-1:0] P_MAX = {PEND_W{1'b1}};

    logic init_wr;
    logic taken;
    assign init_wr = wr_en && (wr_sel == 2'd0);
    assign taken   = irq_ack && irq_req;

    // R9: a request needs a pending expiry and an open mask
    a_r9_req_needs_open: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (!entry_masked && pend_cnt != '0));

    // R9: accepted acknowledge without expiry retires one
    a_r9_ack_retires: assert property (@(posedge clk) disable iff (rst)
        (taken && !expire && sw_enable && !init_wr)
        |=> pend_cnt == $past(pend_cnt) - P_ONE);

    // R8: lone expiry adds one below saturation
    a_r8_expiry_counts: assert property (@(posedge clk) disable iff (rst)
        (expire && !taken && sw_enable && !init_wr && pend_cnt != P_MAX)
        |=> pend_cnt == $past(pend_cnt) + P_ONE);

    // R10: coincident expiry and acknowledge cancel
    a_r10_coincide: assert property (@(posedge clk) disable iff (rst)
        (expire && taken && sw_enable && !init_wr) |=> $stable(pend_cnt));

    // R12: disable forces mask and drops pending
    a_r12_disable_masks: assert property (@(posedge clk) disable iff (rst)
        !sw_enable |=> (entry_masked && pend_cnt == '0 && !irq_req));

    // R3: loading the start count clears pending
    a_r3_load_clears: assert property (@(posedge clk) disable iff (rst)
        init_wr |=> pend_cnt == '0);

    // R4: zero start count leaves the timer idle
    a_r4_zero_idle: assert property (@(posedge clk) disable iff (rst)
        (init_wr && wr_count == '0) |=> (cur_count == '0 && !expire));

endmodule

bind lit_timer lit_timer_chk #(
    .CNT_W  (CNT_W),
    .PEND_W (PEND_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .sw_enable    (sw_enable),
    .wr_en        (wr_en),
    .wr_sel       (wr_sel),
    .wr_count     (wr_data[CNT_W-1:0]),
    .irq_ack      (irq_ack),
    .irq_req      (irq_req),
    .entry_masked (timer_entry[16]),
    .cur_count    (cur_count),
    .expire       (expire_w),
    .pend_cnt     (pend_q)
);

// File: tb/tb_lit_timer.sv
module tb_lit_timer;

    localparam int CLK_NS = 10;
    localparam int CNT_W  = 32;
    localparam int PEND_W = 3;
    localparam int MINP   = 40;
    localparam int PMAX   = (1 << PEND_W) - 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             sw_enable = 1'b0;
    logic             wr_en = 1'b0;
    logic [1:0]       wr_sel = 2'd3;
    logic [31:0]      wr_data = '0;
    logic             irq_ack = 1'b0;
    logic             irq_req;
    logic [7:0]       irq_vector;
    logic [31:0]      timer_entry;
    logic [CNT_W-1:0] cur_count;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #(CLK_NS/2) clk = ~clk;

    lit_timer #(.CNT_W(CNT_W), .PEND_W(PEND_W), .MIN_PERIOD(MINP)) dut (
        .clk(clk), .rst(rst), .sw_enable(sw_enable), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .irq_ack(irq_ack),
        .irq_req(irq_req), .irq_vector(irq_vector),
        .timer_entry(timer_entry), .cur_count(cur_count)
    );

    // ---------------- reference model from the requirements ----------------
    logic [38:0] m_per, m_rem, m_p;
    logic [31:0] m_entry;
    logic [3:0]  m_div;
    int          m_pend, m_next;
    logic        m_exp, m_take, m_per_mode;

    function automatic int ratio_log(input logic [3:0] c);
        return ({29'd0, c[3], c[1:0]} + 1) % 8;
    endfunction

    function automatic logic [31:0] exp_count();
        if (m_rem == 0 || m_rem == m_per) return 32'd0;
        return 32'(m_rem >> ratio_log(m_div));
    endfunction

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (rst) begin
            m_per = '0; m_rem = '0; m_entry = 32'h0001_0000; m_div = '0; m_pend = 0;
        end else begin
            m_exp      = 1'b0;
            m_per_mode = m_entry[17];
            m_take     = irq_ack && (m_pend != 0) && !m_entry[16];
            if (wr_en && wr_sel == 2'd0) begin
                m_p = 39'(wr_data) << ratio_log(m_div);
                if (wr_data != 0 && m_per_mode && m_p < 39'(MINP)) m_p = 39'(MINP);
                m_per = m_p;
                m_rem = m_p;
            end else if (m_rem != 0) begin
                if (m_rem == 1) begin
                    m_exp = 1'b1;
                    m_rem = m_per_mode ? m_per : '0;
                end else begin
                    m_rem = m_rem - 1;
                end
            end
            if (!sw_enable || (wr_en && wr_sel == 2'd0)) begin
                m_pend = 0;
            end else begin
                m_next = m_pend + (m_exp ? 1 : 0) - (m_take ? 1 : 0);
                m_pend = (m_next > PMAX) ? PMAX : m_next;
            end
            if (wr_en && wr_sel == 2'd2) m_entry = wr_data & 32'h0003_10FF;
            if (!sw_enable) m_entry[16] = 1'b1;
            if (wr_en && wr_sel == 2'd1) m_div = wr_data[3:0];
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: actual 0x%0h expected 0x%0h", req, cyc, act, exp);
        end
    endtask

    // Continuous comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (!rst) begin
            chk("R5 cur_count", 64'(cur_count), 64'(exp_count()));
            chk("R9 irq_req", 64'(irq_req), 64'((m_pend != 0) && !m_entry[16]));
            chk("R9 irq_vector", 64'(irq_vector), 64'(m_entry[7:0]));
            chk("R11 timer_entry", 64'(timer_entry), 64'(m_entry));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 2'd3;
    endtask

    task automatic ack_pulse();
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    task automatic wait_irq(input int start, output int n);
        n = start;
        while (!irq_req && n < 6000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic wait_cyc(input int target);
        while (cyc < target) @(negedge clk);
    endtask

    task automatic drain(output int k);
        k = 0;
        while (irq_req && k < 20) begin
            ack_pulse();
            k++;
        end
    endtask

    logic [3:0] codes [4] = '{4'h0, 4'hB, 4'h3, 4'hA};
    int         ratios[4] = '{2, 1, 16, 128};

    initial begin
        int n, k, e0;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 entry", 64'(timer_entry), 64'h0001_0000);
        chk("R1 count", 64'(cur_count), 64'd0);
        chk("R1 irq", 64'(irq_req), 64'd0);
        rst = 1'b0;
        sw_enable = 1'b1;
        @(negedge clk);

        // R11: only kept bits survive a write
        wr(2'd2, 32'hFFFF_FFFF);
        chk("R11 kept bits", 64'(timer_entry), 64'h0003_10FF);
        wr(2'd3, 32'h0000_0000);
        chk("R11 sel 3 writes nothing", 64'(timer_entry), 64'h0003_10FF);
        wr(2'd2, 32'h0000_0055);

        // R2/R5/R6: divide encodings with a one-shot count of 3
        for (int i = 0; i < 4; i++) begin
            wr(2'd1, {28'd0, codes[i]});
            wr(2'd0, 32'd3);
            chk("R5 full period reads 0", 64'(cur_count), 64'd0);
            @(negedge clk);
            chk("R5 first tick", 64'(cur_count), 64'((3 * ratios[i] - 1) / ratios[i]));
            wait_irq(2, n);
            chk("R2 expiry time", 64'(n), 64'(3 * ratios[i] + 1));
            chk("R9 vector", 64'(irq_vector), 64'h55);
            ack_pulse();
            chk("R9 ack retires", 64'(irq_req), 64'd0);
            chk("R6 stopped count", 64'(cur_count), 64'd0);
            repeat (3 * 3 * ratios[i]) @(negedge clk);
            chk("R6 no second expiry", 64'(irq_req), 64'd0);
        end

        // R4: zero start count
        wr(2'd0, 32'd0);
        repeat (30) @(negedge clk);
        chk("R4 count", 64'(cur_count), 64'd0);
        chk("R4 no expiry", 64'(irq_req), 64'd0);

        // R7: clamp and unclamped periodic
        wr(2'd1, 32'hB);
        wr(2'd2, 32'h0002_0021);
        wr(2'd0, 32'd2);
        wait_irq(1, n);
        chk("R7 clamped period", 64'(n), 64'(MINP + 1));
        ack_pulse();
        wr(2'd1, 32'h0);
        wr(2'd0, 32'd30);
        wait_irq(1, n);
        chk("R7 unclamped period", 64'(n), 64'd61);
        ack_pulse();
        wait_irq(1, n);
        chk("R7 reload period", 64'(n), 64'd60);

        // R10: expiry and acknowledge on the same edge
        wr(2'd1, 32'hB);
        wr(2'd2, 32'h0003_0021);
        wr(2'd0, 32'd1);
        e0 = cyc;
        wait_cyc(e0 + 100);
        chk("R9 masked holds request", 64'(irq_req), 64'd0);
        wr(2'd2, 32'h0002_0021);
        chk("R9 unmask raises", 64'(irq_req), 64'd1);
        wait_cyc(e0 + 119);
        ack_pulse();
        drain(k);
        chk("R10 pending after coincidence", 64'(k), 64'd2);

        // R8: saturation
        wr(2'd2, 32'h0003_0021);
        wr(2'd0, 32'd1);
        e0 = cyc;
        wait_cyc(e0 + 405);
        wr(2'd2, 32'h0002_0021);
        drain(k);
        chk("R8 saturated count", 64'(k), 64'(PMAX));
        wait_cyc(e0 + 445);
        chk("R8 next expiry", 64'(irq_req), 64'd1);
        wr(2'd0, 32'd0);
        chk("R3 load clears pending", 64'(irq_req), 64'd0);

        // R12: software disable
        wr(2'd2, 32'h0002_0021);
        wr(2'd0, 32'd1);
        wait_irq(1, n);
        sw_enable = 1'b0;
        @(negedge clk);
        chk("R12 mask forced", 64'(timer_entry[16]), 64'd1);
        chk("R12 no request", 64'(irq_req), 64'd0);
        wr(2'd2, 32'h0000_0033);
        chk("R12 write forced masked", 64'(timer_entry), 64'h0001_0033);
        wr(2'd0, 32'd0);
        sw_enable = 1'b1;
        wr(2'd2, 32'h0000_0033);
        chk("R12 pending dropped", 64'(irq_req), 64'd0);

        // Random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            int r;
            @(negedge clk);
            r = int'($urandom % 100);
            wr_en = 1'b0; wr_sel = 2'd3;
            irq_ack = ($urandom % 3) == 0;
            if (r < 4) begin
                wr_en = 1'b1; wr_sel = 2'd0; wr_data = $urandom % 24;
            end else if (r < 7) begin
                wr_en = 1'b1; wr_sel = 2'd1; wr_data = $urandom;
            end else if (r < 11) begin
                wr_en = 1'b1; wr_sel = 2'd2;
                wr_data = ($urandom % 4 == 0) ? $urandom : ($urandom & 32'hFFFE_FFFF);
            end else if (r < 13) begin
                wr_en = 1'b1; wr_sel = 2'd3; wr_data = $urandom;
            end else if (r < 14) begin
                sw_enable = ~sw_enable;
            end else if (!sw_enable && r > 90) begin
                sw_enable = 1'b1;
            end
        end
        @(negedge clk);
        wr_en = 1'b0; irq_ack = 1'b0;
        @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_NS * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired at cycle %0d: actual running expected finished", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule